// File: doc/BRIEF.md
# Mode-Selected Fixed-Point Ratio Unit

This block turns one of four stored 32-bit ratio words into a single effective multiplication ratio for a clock-multiplying loop. Two asynchronous mode pins select one of four configuration sets. Each set holds a ratio word and a 2-bit divide selection. A global format bit decides how the 32-bit word is read: as a high-resolution value with 12 integer bits and 20 fraction bits, or as a high-multiplication value with 20 integer bits and 12 fraction bits. The result is always an unsigned 20.20 value, 40 bits wide.

A third asynchronous pin, the auxiliary mode pin, can divide the selected ratio by 2, 4, 8 or 16. It does this only when its 3-bit role configuration enables that use. The reference-clock pre-divider setting is folded into the ratio as a left shift, so the stored words never have to account for it. The reserved divider code raises an error flag.

Any pin change that alters the ratio raises a one-cycle relock request for the loop. A part that was programmed in the field reports itself ready only after the two select pins have made three transitions since reset. The stored words and settings arrive on plain input ports.

Top module: `ratio_mode_unit`

## Requirements
- R1: Select pins value k (0 to 3) picks ratio word `set_ratio_i[32k+31:32k]` and divide code `set_mod_i[2k+1:2k]`.
- R2: With `hi_res_fmt_i`=1 the word is read as 12.20, giving `{8'b0, word}`. With `hi_res_fmt_i`=0 it is read as 20.12, giving `{word, 8'b0}`. Output bits 39:20 are the integer part and bits 19:0 the fraction.
- R3: When `aux_cfg_i`=3'b011 and the synchronized auxiliary pin is high, divide codes 00, 01, 10 and 11 shift the ratio right by 1, 2, 3 and 4 bits.
- R4: In any other combination of `aux_cfg_i` and the auxiliary pin, the divide code has no effect on the ratio.
- R5: `ref_div_i` 00 shifts the ratio left by 2, 01 by 1 and 10 by 0. Code 11 shifts by 0 and raises `ref_div_err_o`. The shift is applied on a 42-bit intermediate before the divide shift, and the result is truncated to 40 bits.
- R6: A change on a stored word or setting appears on `eff_ratio_o` and `ref_div_err_o` after one rising edge. A change on a mode pin appears after three rising edges.
- R7: A change of the select pins raises `relock_o` for one cycle, on the third rising edge after the change.
- R8: A change of the auxiliary pin raises `relock_o` only while `aux_cfg_i` is 011, 100, 101 or 110. Under any other code it causes no relock.
- R9: With `field_prog_i`=1, `init_done_o` stays low until three select-pin transitions have been counted. Each changing pin counts once, so a simultaneous change of both pins counts two. Once high, it stays high until reset. With `field_prog_i`=0, `init_done_o` is high.
- R10: While `rst_n` is low, `eff_ratio_o`, `ref_div_err_o` and `relock_o` are 0, the transition count is cleared, and the synchronizers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Asynchronous set-select pins |
| mode_aux_i | input | 1 | Asynchronous auxiliary mode pin |
| set_ratio_i | input | 128 | Four stored ratio words, set k at bits 32k+31:32k |
| set_mod_i | input | 8 | Four divide codes, set k at bits 2k+1:2k |
| hi_res_fmt_i | input | 1 | 1: word is 12.20, 0: word is 20.12 |
| aux_cfg_i | input | 3 | Role of the auxiliary pin |
| ref_div_i | input | 2 | Reference pre-divider code |
| field_prog_i | input | 1 | Part programmed in the field; enables the readiness gate |
| eff_ratio_o | output | 40 | Effective ratio, unsigned 20.20 |
| ref_div_err_o | output | 1 | Reserved divider code in use |
| relock_o | output | 1 | One-cycle relock request |
| init_done_o | output | 1 | Mode pins have made enough transitions since reset |

## Verification
Configuration inputs reach the ratio output and the error flag on the first rising edge. Mode pins pass two synchronizer stages and one output or detector register, so the ratio, the relock pulse and the transition count are due on the third edge after the pin changes. The bench keeps the pin values it applied at each edge in a short queue. From the entries two and three edges old it computes the expected ratio, relock and count, then compares every output at the following falling edge, on every cycle, including the cycles spent in reset.

// File: rtl/rmu_pkg.sv
`timescale 1ns/1ps
package rmu_pkg;
   typedef enum logic [1:0] {
      REFDIV_BY4  = 2'b00,
      REFDIV_BY2  = 2'b01,
      REFDIV_BY1  = 2'b10,
      REFDIV_RSVD = 2'b11
   } refdiv_e;

   localparam logic [2:0] AUX_ROLE_DIVIDE = 3'b011;
   localparam int unsigned MAX_REF_LSHIFT = 2;

   // auxiliary-pin roles whose toggling disturbs the loop
   function automatic logic aux_role_relocks(input logic [2:0] role);
      return (role == 3'b011) || (role == 3'b100) || (role == 3'b101) || (role == 3'b110);
   endfunction

   function automatic logic [1:0] refdiv_lshift(input refdiv_e code);
      case (code)
         REFDIV_BY4: return 2'd2;
         REFDIV_BY2: return 2'd1;
         default:    return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/rmu_sync.sv
`timescale 1ns/1ps
module rmu_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rmu_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("rmu_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rmu_ratio_path.sv
`timescale 1ns/1ps
module rmu_ratio_path
   import rmu_pkg::*;
#(
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned RATIO_W  = 32,
   parameter int unsigned MOD_W    = 2,
   parameter int unsigned HR_FRAC  = 20,
   parameter int unsigned LR_FRAC  = 12,
   parameter int unsigned OUT_INT  = 20,
   parameter int unsigned OUT_FRAC = 20,
   localparam int unsigned NSETS   = 2 ** SEL_W,
   localparam int unsigned OUT_W   = OUT_INT + OUT_FRAC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SEL_W-1:0]         sel_i,
   input  logic                     aux_i,
   input  logic [NSETS*RATIO_W-1:0] words_i,
   input  logic [NSETS*MOD_W-1:0]   mods_i,
   input  logic                     hi_res_i,
   input  logic [2:0]               aux_cfg_i,
   input  logic [1:0]               ref_div_i,
   output logic [OUT_W-1:0]         eff_o,
   output logic                     err_o
);
   localparam int unsigned WIDE_W = OUT_W + MAX_REF_LSHIFT;
   localparam int unsigned HR_ALN = OUT_FRAC - HR_FRAC;
   localparam int unsigned LR_ALN = OUT_FRAC - LR_FRAC;
   localparam int unsigned RSH_W  = MOD_W + 1;

   generate
      if (OUT_FRAC < HR_FRAC || OUT_FRAC < LR_FRAC) begin : g_bad_frac
         $error("rmu_ratio_path: output fraction narrower than an input format");
      end
      if (OUT_INT < RATIO_W - LR_FRAC || OUT_INT < RATIO_W - HR_FRAC) begin : g_bad_int
         $error("rmu_ratio_path: output integer part narrower than an input format");
      end
   endgenerate

   logic [RATIO_W-1:0] word_a [NSETS];
   logic [MOD_W-1:0]   mod_a  [NSETS];

   generate
      for (genvar k = 0; k < NSETS; k++) begin : g_unpack
         assign word_a[k] = words_i[k*RATIO_W +: RATIO_W];
         assign mod_a[k]  = mods_i[k*MOD_W +: MOD_W];
      end
   endgenerate

   logic [WIDE_W-1:0] conv, shifted, divided;
   logic [1:0]        lsh;
   logic [RSH_W-1:0]  rsh;
   logic              div_en;

   always_comb begin
      conv    = hi_res_i ? (WIDE_W'(word_a[sel_i]) << HR_ALN)
                         : (WIDE_W'(word_a[sel_i]) << LR_ALN);
      lsh     = refdiv_lshift(refdiv_e'(ref_div_i));
      shifted = conv << lsh;
      div_en  = (aux_cfg_i == AUX_ROLE_DIVIDE) && aux_i;
      rsh     = RSH_W'(mod_a[sel_i]) + RSH_W'(1);
      divided = div_en ? (shifted >> rsh) : shifted;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_o <= '0;
         err_o <= 1'b0;
      end else begin
         eff_o <= divided[OUT_W-1:0];
         err_o <= (refdiv_e'(ref_div_i) == REFDIV_RSVD);
      end
   end

   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   AST_ERR_ONLY_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($past(ref_div_i) == 2'b11)); // R5

   AST_RATIO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $stable(sel_i) && $stable(aux_i) && $stable(words_i) && $stable(mods_i)
       && $stable(hi_res_i) && $stable(aux_cfg_i) && $stable(ref_div_i))
      |=> $stable(eff_o)); // R6
endmodule

// File: rtl/rmu_mode_watch.sv
`timescale 1ns/1ps
module rmu_mode_watch
   import rmu_pkg::*;
#(
   parameter int unsigned SEL_W        = 2,
   parameter int unsigned INIT_TOGGLES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             aux_i,
   input  logic [2:0]       aux_cfg_i,
   input  logic             field_prog_i,
   output logic             relock_o,
   output logic             init_done_o
);
   localparam int unsigned CNT_W = $clog2(INIT_TOGGLES + SEL_W + 1);

   generate
      if (INIT_TOGGLES < 1) begin : g_bad_init
         $error("rmu_mode_watch: INIT_TOGGLES must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] sel_p;
   logic             aux_p;
   logic [CNT_W-1:0] cnt_q, cnt_sum;
   logic             changed;

   always_comb begin
      changed = (sel_i != sel_p) || ((aux_i != aux_p) && aux_role_relocks(aux_cfg_i));
      cnt_sum = cnt_q + CNT_W'($countones(sel_i ^ sel_p));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_p    <= '0;
         aux_p    <= 1'b0;
         relock_o <= 1'b0;
         cnt_q    <= '0;
      end else begin
         sel_p    <= sel_i;
         aux_p    <= aux_i;
         relock_o <= changed;
         cnt_q    <= (cnt_sum >= CNT_W'(INIT_TOGGLES)) ? CNT_W'(INIT_TOGGLES) : cnt_sum;
      end
   end

   assign init_done_o = !field_prog_i || (cnt_q >= CNT_W'(INIT_TOGGLES));

   AST_RELOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(sel_i) && $stable(aux_i)) |=> !relock_o); // R7

   AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q >= $past(cnt_q)); // R9
endmodule

// File: rtl/ratio_mode_unit.sv
`timescale 1ns/1ps
module ratio_mode_unit #(
   parameter int unsigned SEL_W        = 2,
   parameter int unsigned RATIO_W      = 32,
   parameter int unsigned MOD_W        = 2,
   parameter int unsigned HR_FRAC      = 20,
   parameter int unsigned LR_FRAC      = 12,
   parameter int unsigned OUT_INT      = 20,
   parameter int unsigned OUT_FRAC     = 20,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned INIT_TOGGLES = 3,
   localparam int unsigned NSETS       = 2 ** SEL_W,
   localparam int unsigned OUT_W       = OUT_INT + OUT_FRAC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SEL_W-1:0]         mode_sel_i,
   input  logic                     mode_aux_i,
   input  logic [NSETS*RATIO_W-1:0] set_ratio_i,
   input  logic [NSETS*MOD_W-1:0]   set_mod_i,
   input  logic                     hi_res_fmt_i,
   input  logic [2:0]               aux_cfg_i,
   input  logic [1:0]               ref_div_i,
   input  logic                     field_prog_i,
   output logic [OUT_W-1:0]         eff_ratio_o,
   output logic                     ref_div_err_o,
   output logic                     relock_o,
   output logic                     init_done_o
);
   logic [SEL_W-1:0] sel_s;
   logic             aux_s;

   rmu_sync #(.W(SEL_W + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({mode_aux_i, mode_sel_i}),
      .q_o   ({aux_s, sel_s})
   );

   rmu_ratio_path #(
      .SEL_W(SEL_W), .RATIO_W(RATIO_W), .MOD_W(MOD_W), .HR_FRAC(HR_FRAC),
      .LR_FRAC(LR_FRAC), .OUT_INT(OUT_INT), .OUT_FRAC(OUT_FRAC)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel_s),
      .aux_i     (aux_s),
      .words_i   (set_ratio_i),
      .mods_i    (set_mod_i),
      .hi_res_i  (hi_res_fmt_i),
      .aux_cfg_i (aux_cfg_i),
      .ref_div_i (ref_div_i),
      .eff_o     (eff_ratio_o),
      .err_o     (ref_div_err_o)
   );

   rmu_mode_watch #(.SEL_W(SEL_W), .INIT_TOGGLES(INIT_TOGGLES)) u_watch (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_i        (sel_s),
      .aux_i        (aux_s),
      .aux_cfg_i    (aux_cfg_i),
      .field_prog_i (field_prog_i),
      .relock_o     (relock_o),
      .init_done_o  (init_done_o)
   );

   AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (field_prog_i && $past(field_prog_i) && $past(init_done_o)) |-> init_done_o); // R9

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (eff_ratio_o == '0 && !relock_o && !ref_div_err_o)); // R10
endmodule

// File: tb/ratio_mode_unit_tb_top.sv
`timescale 1ns/1ps
module ratio_mode_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode_sel = 2'b00;
   logic         mode_aux = 1'b0;
   logic [31:0]  ratios [4];
   logic [1:0]   mods [4];
   logic         hi_res = 1'b1;
   logic [2:0]   aux_cfg = 3'b000;
   logic [1:0]   ref_div = 2'b10;
   logic         field_prog = 1'b1;
   logic [127:0] ratio_bus;
   logic [7:0]   mod_bus;
   logic [39:0]  eff_ratio;
   logic         ref_div_err, relock, init_done;

   always #2.5 clk = ~clk;

   assign ratio_bus = {ratios[3], ratios[2], ratios[1], ratios[0]};
   assign mod_bus   = {mods[3], mods[2], mods[1], mods[0]};

   ratio_mode_unit dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .mode_aux_i(mode_aux),
      .set_ratio_i(ratio_bus), .set_mod_i(mod_bus), .hi_res_fmt_i(hi_res),
      .aux_cfg_i(aux_cfg), .ref_div_i(ref_div), .field_prog_i(field_prog),
      .eff_ratio_o(eff_ratio), .ref_div_err_o(ref_div_err), .relock_o(relock),
      .init_done_o(init_done)
   );

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   // reference model: pins applied at past edges, oldest first (length 3)
   logic [1:0] hist_sel [$];
   logic       hist_aux [$];
   int         m_cnt;
   logic [39:0] exp_eff;
   logic        exp_err, exp_relock;

   function automatic logic [39:0] ref_ratio(input logic [1:0] s, input logic a);
      logic [63:0] v;
      v = hi_res ? {32'b0, ratios[s]} : ({32'b0, ratios[s]} << 8);       // R2
      if (ref_div == 2'b00) v = v << 2;                                  // R5
      else if (ref_div == 2'b01) v = v << 1;
      if (aux_cfg == 3'b011 && a) v = v >> (int'(mods[s]) + 1);          // R3 R4
      return v[39:0];
   endfunction

   task automatic model_edge();
      logic [1:0] s2, s3;
      logic a2, a3;
      if (!rst_n) begin
         hist_sel = '{2'b00, 2'b00, 2'b00};
         hist_aux = '{1'b0, 1'b0, 1'b0};
         m_cnt = 0; exp_eff = '0; exp_err = 1'b0; exp_relock = 1'b0;  // R10
      end else begin
         s2 = hist_sel[1]; s3 = hist_sel[0];
         a2 = hist_aux[1]; a3 = hist_aux[0];
         exp_eff    = ref_ratio(s2, a2);
         exp_err    = (ref_div == 2'b11);
         exp_relock = (s2 != s3) ||
                      ((a2 != a3) && (aux_cfg >= 3'b011) && (aux_cfg <= 3'b110)); // R7 R8
         m_cnt = m_cnt + $countones(s2 ^ s3);
         if (m_cnt > 3) m_cnt = 3;
         hist_sel.push_back(mode_sel); void'(hist_sel.pop_front());
         hist_aux.push_back(mode_aux); void'(hist_aux.pop_front());
      end
   endtask

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 R2 R3 R4 R5 R6 eff_ratio", 64'(eff_ratio), 64'(exp_eff));
      chk("R5 ref_div_err", 64'(ref_div_err), 64'(exp_err));
      chk("R7 R8 relock", 64'(relock), 64'(exp_relock));
      chk("R9 init_done", 64'(init_done), 64'(!field_prog || m_cnt >= 3));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic print_summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired actual=running expected=done");
         print_summary();
         $finish;
      end
   end

   initial begin
      ratios[0] = 32'h0018_0000; ratios[1] = 32'h3000_4000;
      ratios[2] = 32'hABC1_2345; ratios[3] = 32'h0007_FFFF;
      mods[0] = 2'b00; mods[1] = 2'b01; mods[2] = 2'b10; mods[3] = 2'b11;
      @(negedge clk);
      step(4);                                   // R10 reset state
      rst_n = 1'b1;
      step(3);
      // R1 walk all sets, R9 count reaches 3 on third transition
      mode_sel = 2'b01; step(5);
      mode_sel = 2'b11; step(5);
      mode_sel = 2'b10; step(5);
      mode_sel = 2'b00; step(5);
      // R2 20.12 reading, R6 config takes one edge
      hi_res = 1'b0; step(2);
      mode_sel = 2'b10; step(5);
      hi_res = 1'b1; step(2);
      // R5 divider compensation and reserved code
      ref_div = 2'b00; step(2);
      ref_div = 2'b01; step(2);
      ref_div = 2'b11; step(2);
      ref_div = 2'b10; step(2);
      // R3 divide codes per set
      aux_cfg = 3'b011; mode_aux = 1'b1; step(5);
      for (int s = 0; s < 4; s++) begin
         mode_sel = 2'(s); step(5);
      end
      // R4 and R8: aux pin under other roles
      mode_aux = 1'b0; step(5);
      aux_cfg = 3'b001; step(2); mode_aux = 1'b1; step(5);
      aux_cfg = 3'b110; step(2); mode_aux = 1'b0; step(5);
      aux_cfg = 3'b111; step(2); mode_aux = 1'b1; step(5);
      aux_cfg = 3'b000; step(2); mode_aux = 1'b0; step(5);
      // R6 word change on the selected set, R5 truncation at the top
      ratios[3] = 32'hFFFF_FFFF; hi_res = 1'b0; ref_div = 2'b00; step(3);
      aux_cfg = 3'b011; mode_aux = 1'b1; step(5);
      // R9 field_prog low forces ready
      field_prog = 1'b0; step(2);
      // R10 second reset, R9 simultaneous transition counts two
      rst_n = 1'b0; field_prog = 1'b1; mode_sel = 2'b00; mode_aux = 1'b0;
      aux_cfg = 3'b000; ref_div = 2'b10; hi_res = 1'b1;
      step(3);
      rst_n = 1'b1; step(3);
      mode_sel = 2'b11; step(5);
      mode_sel = 2'b10; step(5);
      mode_sel = 2'b00; step(5);
      finished = 1'b1;
      print_summary();
      $finish;
   end
endmodule